// File: doc/BRIEF.md
# Transmit Test Pattern Generator for a Dual-Speed Ethernet PHY

This block sits in the transmit path of a 10/100 Ethernet PHY, just ahead of the line driver. It holds a 16-bit control word. When test operation is off, the normal transmit bit and its valid flag pass straight through. When test operation is on and a speed enable is set, the block replaces the normal stream with a generated pattern. A power-down field tells the driver to tri-state its outputs.

The block runs on one clock, and each clock is one symbol. In 100 Mb mode a symbol is a line bit. The generator repeats one of four fixed bit patterns. In 10 Mb mode a symbol is a half-bit at 20 MHz. A state machine with the states T10_DATA, T10_EOP, T10_GAP, T10_PULSE and T10_TONE produces one of four sequences:

- a Manchester-coded payload followed by one of two end-of-packet forms, then an idle gap;
- a link pulse followed by an idle gap;
- a constant Manchester-ones tone.

The machine moves between states as follows:

- DATA→EOP after the last payload half-bit.
- EOP→GAP after the end-of-packet ticks.
- PULSE→GAP after the pulse ticks.
- GAP→DATA or GAP→PULSE after the gap, depending on the selected sequence.
- TONE stays in TONE.

A restart loads the entry state for the new selection: DATA for selects 0 and 1, PULSE for select 2, TONE for select 3.

Top module: `phy_tx_pattern_gen`

## Requirements
- R1: After reset, the control word reads 0x0000, `tx_pd` is 0, and the outputs follow `norm_bit`/`norm_valid`.
- R2: Control word fields are:
  - bit 15: power-down
  - bit 11: test enable
  - bit 4: 10 Mb enable
  - bit 3: 100 Mb enable
  - bit 2: long gap
  - bits 1:0: pattern select

  All other bits ignore writes and always read 0.
- R3: With test enable at 0, or with neither speed enable set, `tx_bit`/`tx_valid` equal `norm_bit`/`norm_valid` in the same cycle.
- R4: With power-down at 1, `tx_pd` is 1 and `tx_valid` and `tx_bit` are both 0, whatever else is set.
- R5: 100 Mb mode has `tx_valid` at 1. Select 00 outputs constant 0 and select 01 outputs constant 1.
- R6: 100 Mb select 10 repeats 1,1,0,0. Select 11 repeats fourteen 1s then six 0s. In both cases symbol k=0 is the cycle that follows the write edge.
- R7: 10 Mb selects 00 and 01 start with 128 half-bit ticks of Manchester payload 1,0,1,0,… Bit 1 is sent as half-bits 1,0 and bit 0 as 0,1, with `tx_valid` at 1.
- R8: After the payload comes 4 ticks with `tx_valid` at 1: `tx_bit` is 1 for select 00 and 0 for select 01.
- R9: After the end-of-packet or link pulse comes an idle gap with `tx_valid` and `tx_bit` both 0. The gap lasts 200 ticks when the long-gap bit is 0 and 300 ticks when it is 1. The sequence then repeats.
- R10: 10 Mb select 10 gives 2 ticks of `tx_bit`=1 with `tx_valid`=1, then the gap.
- R11: 10 Mb select 11 gives `tx_valid`=1 and a `tx_bit` that alternates 1,0,1,0,… starting at 1.
- R12: A write that changes any of bits 11, 4, 3, 2, 1:0 restarts the pattern at symbol 0 in the cycle after the write edge. A write that leaves those bits unchanged does not disturb the running phase.
- R13: When both speed enables are set, the 100 Mb pattern is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock (100 Mb bit / 10 Mb half-bit) |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Current control word |
| norm_bit | input | 1 | Normal transmit bit |
| norm_valid | input | 1 | Normal transmit valid |
| tx_bit | output | 1 | Serial bit to the driver |
| tx_valid | output | 1 | 1 = symbol active, 0 = idle |
| tx_pd | output | 1 | Driver power-down / tri-state request |

## Verification
Two situations are hardest to reach from the ports:

- The wrap from the end of a 10 Mb gap back into payload or pulse, which takes a long idle run with the 300-tick gap selected.
- A mid-pattern rewrite that must not disturb the phase.

Before each random configuration, the stimulus first writes a neutral control word. This forces a real restart. It then observes more than one full period, so every gap end and repeat is checked. A directed case rewrites an unchanged 100 Mb control word partway through the 20-symbol period and checks that the phase continues.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

    typedef struct packed {
        logic       pd;
        logic [2:0] rsv_hi;
        logic       test_en;
        logic [2:0] rsv_mid;
        logic [2:0] rsv_lo;
        logic       en10;
        logic       en100;
        logic       gap_long;
        logic [1:0] sel;
    } ptg_cfg_t;

    // Writable bits of the control word
    localparam logic [15:0] CFG_WMASK    = 16'h881F;
    // Bits whose change restarts the pattern
    localparam logic [15:0] CFG_MODEMASK = 16'h081F;

    typedef enum logic [2:0] {
        T10_DATA,
        T10_EOP,
        T10_GAP,
        T10_PULSE,
        T10_TONE
    } t10_state_e;

endpackage

// File: rtl/ptg_ctrl.sv
module ptg_ctrl
    import ptg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [15:0] wdata,
    output ptg_cfg_t    cfg_q,
    output ptg_cfg_t    cfg_nxt,
    output logic        restart
);

    always_comb begin
        cfg_nxt = we ? ptg_cfg_t'(wdata & CFG_WMASK) : cfg_q;
        restart = we && (((wdata & CFG_MODEMASK) ^ (16'(cfg_q) & CFG_MODEMASK)) != 16'h0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_nxt;
    end

endmodule

// File: rtl/ptg_pat100.sv
module ptg_pat100 #(
    parameter int PAIR_LEN   = 2,
    parameter int LONG_ONES  = 14,
    parameter int LONG_ZEROS = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [1:0] sel,
    output logic       bit_o
);

    localparam int SHORT_PER = 2 * PAIR_LEN;
    localparam int LONG_PER  = LONG_ONES + LONG_ZEROS;
    localparam int SW        = $clog2(SHORT_PER);
    localparam int LW        = $clog2(LONG_PER);

    logic [SW-1:0] ph_s;
    logic [LW-1:0] ph_l;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            ph_s <= '0;
            ph_l <= '0;
        end else begin
            ph_s <= (ph_s == SW'(SHORT_PER - 1)) ? '0 : ph_s + 1'b1;
            ph_l <= (ph_l == LW'(LONG_PER - 1))  ? '0 : ph_l + 1'b1;
        end
    end

    always_comb begin
        unique case (sel)
            2'b00: bit_o = 1'b0;
            2'b01: bit_o = 1'b1;
            2'b10: bit_o = (ph_s < SW'(PAIR_LEN));
            2'b11: bit_o = (ph_l < LW'(LONG_ONES));
        endcase
    end

endmodule

// File: rtl/ptg_pat10.sv
module ptg_pat10
    import ptg_pkg::*;
#(
    parameter int DATA_BITS   = 64,
    parameter int EOP_TICKS   = 4,
    parameter int PULSE_TICKS = 2,
    parameter int GAP_SHORT   = 200,
    parameter int GAP_LONG    = 300
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [1:0] entry_sel,
    input  logic [1:0] sel,
    input  logic       gap_long,
    output logic       bit_o,
    output logic       valid_o
);

    localparam int DATA_TICKS = 2 * DATA_BITS;
    localparam int MAX_A      = (DATA_TICKS > GAP_LONG) ? DATA_TICKS : GAP_LONG;
    localparam int MAX_B      = (GAP_SHORT > EOP_TICKS) ? GAP_SHORT : EOP_TICKS;
    localparam int CNT_MAX    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW         = $clog2(CNT_MAX + 1);

    localparam logic [CW-1:0] DATA_LAST  = CW'(DATA_TICKS - 1);
    localparam logic [CW-1:0] EOP_LAST   = CW'(EOP_TICKS - 1);
    localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_TICKS - 1);
    localparam logic [CW-1:0] GS_LAST    = CW'(GAP_SHORT - 1);
    localparam logic [CW-1:0] GL_LAST    = CW'(GAP_LONG - 1);

    t10_state_e    state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic [CW-1:0] gap_last;

    function automatic t10_state_e entry_of(input logic [1:0] s);
        unique case (s)
            2'b00, 2'b01: entry_of = T10_DATA;
            2'b10:        entry_of = T10_PULSE;
            2'b11:        entry_of = T10_TONE;
        endcase
    endfunction

    assign gap_last = gap_long ? GL_LAST : GS_LAST;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt + 1'b1;
        unique case (state)
            T10_DATA:  if (cnt == DATA_LAST)  begin state_nx = T10_EOP; cnt_nx = '0; end
            T10_EOP:   if (cnt == EOP_LAST)   begin state_nx = T10_GAP; cnt_nx = '0; end
            T10_PULSE: if (cnt == PULSE_LAST) begin state_nx = T10_GAP; cnt_nx = '0; end
            T10_GAP:   if (cnt == gap_last)   begin state_nx = entry_of(sel); cnt_nx = '0; end
            T10_TONE:  state_nx = T10_TONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= T10_DATA;
            cnt   <= '0;
        end else if (restart) begin
            state <= entry_of(entry_sel);
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        bit_o   = 1'b0;
        valid_o = 1'b1;
        unique case (state)
            T10_DATA:  bit_o = ~cnt[1] ^ cnt[0];
            T10_EOP:   bit_o = ~sel[0];
            T10_PULSE: bit_o = 1'b1;
            T10_GAP:   valid_o = 1'b0;
            T10_TONE:  bit_o = ~cnt[0];
        endcase
    end

endmodule

// File: rtl/phy_tx_pattern_gen.sv
module phy_tx_pattern_gen
    import ptg_pkg::*;
#(
    parameter int DATA_BITS = 64,
    parameter int GAP_SHORT = 200,
    parameter int GAP_LONG  = 300
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [15:0] cfg_wdata,
    output logic [15:0] cfg_rdata,
    input  logic        norm_bit,
    input  logic        norm_valid,
    output logic        tx_bit,
    output logic        tx_valid,
    output logic        tx_pd
);

    ptg_cfg_t cfg_q, cfg_nxt;
    logic     restart;
    logic     mode100, mode10;
    logic     p100_bit, p10_bit, p10_valid;

    ptg_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .cfg_q   (cfg_q),
        .cfg_nxt (cfg_nxt),
        .restart (restart)
    );

    assign mode100 = cfg_q.test_en & cfg_q.en100;
    assign mode10  = cfg_q.test_en & cfg_q.en10 & ~cfg_q.en100;

    ptg_pat100 u_p100 (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart | ~mode100),
        .sel     (cfg_q.sel),
        .bit_o   (p100_bit)
    );

    ptg_pat10 #(
        .DATA_BITS (DATA_BITS),
        .GAP_SHORT (GAP_SHORT),
        .GAP_LONG  (GAP_LONG)
    ) u_p10 (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart | ~mode10),
        .entry_sel (cfg_nxt.sel),
        .sel       (cfg_q.sel),
        .gap_long  (cfg_q.gap_long),
        .bit_o     (p10_bit),
        .valid_o   (p10_valid)
    );

    assign cfg_rdata = 16'(cfg_q);
    assign tx_pd     = cfg_q.pd;

    always_comb begin
        if (cfg_q.pd) begin
            tx_bit   = 1'b0;
            tx_valid = 1'b0;
        end else if (mode100) begin
            tx_bit   = p100_bit;
            tx_valid = 1'b1;
        end else if (mode10) begin
            tx_bit   = p10_bit;
            tx_valid = p10_valid;
        end else begin
            tx_bit   = norm_bit;
            tx_valid = norm_valid;
        end
    end

endmodule

// File: rtl/ptg_chk.sv
module ptg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [15:0] cfg_wdata,
    input logic [15:0] cfg_rdata,
    input logic        norm_bit,
    input logic        norm_valid,
    input logic        tx_bit,
    input logic        tx_valid,
    input logic        tx_pd
);

    logic tone, short100;
    assign tone     = cfg_rdata[11] & cfg_rdata[4] & ~cfg_rdata[3] & ~cfg_rdata[15] & (cfg_rdata[1:0] == 2'b11);
    assign short100 = cfg_rdata[11] & cfg_rdata[3] & ~cfg_rdata[15] & (cfg_rdata[1:0] == 2'b10);

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & 16'h77E0) == 16'h0);

    // R4
    pd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[15] |-> (tx_pd && !tx_valid && !tx_bit));

    // R3
    pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rdata[11] && !cfg_rdata[15]) |-> (tx_bit == norm_bit && tx_valid == norm_valid));

    // R5
    quiet100_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[11] && cfg_rdata[3] && !cfg_rdata[15] && cfg_rdata[1:0] == 2'b00) |-> (tx_valid && !tx_bit));

    // R11
    tone_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tone && $past(tone) && !$past(cfg_we)) |-> (tx_bit != $past(tx_bit)));

    // R6
    pair_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (short100 && $past(short100) && $past(short100, 2) && !$past(cfg_we) && !$past(cfg_we, 2))
        |-> (tx_bit != $past(tx_bit, 2)));

endmodule

bind phy_tx_pattern_gen ptg_chk i_ptg_chk (.*);

// File: tb/test_phy_tx_pattern_gen.sv
module test_phy_tx_pattern_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        norm_bit = 1'b0;
    logic        norm_valid = 1'b0;
    logic        tx_bit, tx_valid, tx_pd;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    phy_tx_pattern_gen i_phy_tx_pattern_gen (.*);

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // Expected {valid, bit} and tag for symbol k of a test configuration
    function automatic logic [1:0] exp_sym(input logic [15:0] c, input int k,
                                           input logic nb, input logic nv, output string tag);
        logic [1:0] s;
        int g, m;
        s = c[1:0];
        g = c[2] ? 300 : 200;
        tag = "R3";
        if (c[15]) begin
            tag = "R4";
            return 2'b00;
        end
        if (c[11] && c[3]) begin
            tag = c[4] ? "R13" : ((s < 2) ? "R5" : "R6");
            case (s)
                2'b00: return 2'b10;
                2'b01: return 2'b11;
                2'b10: return {1'b1, logic'((k % 4) < 2)};
                default: return {1'b1, logic'((k % 20) < 14)};
            endcase
        end
        if (c[11] && c[4]) begin
            if (s == 2'b11) begin
                tag = "R11";
                return {1'b1, logic'((k % 2) == 0)};
            end
            if (s == 2'b10) begin
                m = k % (2 + g);
                tag = (m < 2) ? "R10" : "R9";
                return (m < 2) ? 2'b11 : 2'b00;
            end
            m = k % (132 + g);
            if (m < 128) begin
                tag = "R7";
                return {1'b1, logic'(((m / 2) % 2 == 0) ^ (m % 2 == 1))};
            end
            if (m < 132) begin
                tag = "R8";
                return {1'b1, logic'(s == 2'b00)};
            end
            tag = "R9";
            return 2'b00;
        end
        return {nv, nb};
    endfunction

    task automatic wr(input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Sample symbols k0..k0+n-1; caller is at the negedge for symbol k0
    task automatic run(input logic [15:0] c, input int k0, input int n);
        string tag;
        logic [1:0] e;
        for (int k = k0; k < k0 + n; k++) begin
            norm_bit = 1'($urandom);
            norm_valid = 1'($urandom);
            #1;
            e = exp_sym(c, k, norm_bit, norm_valid, tag);
            check(tag, {30'd0, tx_valid, tx_bit}, {30'd0, e});
            @(negedge clk);
        end
    endtask

    initial begin
        logic [15:0] c;
        int len;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        check("R1", 32'(cfg_rdata), 32'h0);
        check("R1", 32'(tx_pd), 32'h0);
        run(16'h0000, 0, 8);

        // R2 reserved bits read zero
        wr(16'hFFFF);
        #1;
        check("R2", 32'(cfg_rdata), 32'h881F);
        // R4 power-down overrides a running pattern
        check("R4", 32'(tx_pd), 32'h1);
        run(16'hFFFF, 0, 6);
        wr(16'h77E0);
        #1;
        check("R2", 32'(cfg_rdata), 32'h0);

        // R3 test enable without speed enable
        wr(16'h0800);
        run(16'h0800, 0, 10);
        // R3 speed enable without test enable
        wr(16'h0009);
        run(16'h0009, 0, 10);

        // R12 identical rewrite keeps phase
        wr(16'h0000);
        wr(16'h080B);
        run(16'h080B, 0, 7);
        wr(16'h080B);
        run(16'h080B, 9, 30);
        // R12 changed write restarts
        wr(16'h080A);
        run(16'h080A, 0, 12);

        // R13 both enables, long-gap pattern 11
        wr(16'h0000);
        wr(16'h081B);
        run(16'h081B, 0, 45);

        // R9 long gap wrap with link pulse, directed
        wr(16'h0000);
        wr(16'h0816);
        run(16'h0816, 0, 620);

        // Constrained random configurations
        for (int it = 0; it < 30; it++) begin
            int md;
            md = $urandom % 3;
            c = 16'h0800 | 16'($urandom % 8);
            c = c | ((md == 0) ? 16'h0008 : (md == 1) ? 16'h0010 : 16'h0018);
            if (md == 0 || md == 2)      len = 50;
            else if (c[1:0] == 2'b11)    len = 40;
            else if (c[1:0] == 2'b10)    len = 2 + (c[2] ? 300 : 200) + 20;
            else                         len = 132 + (c[2] ? 300 : 200) + 140;
            wr(16'h0000);
            wr(c);
            run(c, 0, len);
        end

        finish_run();
    end

endmodule